// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the device side of a byte-oriented serial programming link. A host drives a serial clock and a data line into the block and reads a return data line back. Bits are gathered into bytes and bytes into fixed four-byte instructions. Each byte the host sends is returned to it during the following byte slot, so the host can tell whether both sides agree on where bytes begin. Instructions take effect only after a programming-enable frame. They fill a word-organised page buffer half a word at a time, commit that buffer to a page of a register-held memory array, read single bytes back, and poll a busy flag that covers the time a commit takes.

The serial pins are plain levels, oversampled in the system clock domain. There is no valid/ready stream at the edge and no back-pressure path. The host sets the pace with the serial clock. It must keep each serial clock phase at least four system clocks long, hold the serial clock low when reset is released, and use the poll instruction, or wait out the busy time, before it sends further work after a commit. The enabled and busy states are also brought out as plain status pins.

Top module: `spi_isp_target`

## Requirements
- R1: `mosi_i` is sampled on rising edges of `sck_i`, most significant bit first. `miso_o` changes only after a falling edge of `sck_i` and stays stable while `sck_i` is high.
- R2: Unless R5 or R9 replace it, the byte on `miso_o` during each byte slot is the byte the host sent in the previous slot. During the third byte of an enable frame, `miso_o` therefore carries 0x53.
- R3: Until a frame with first byte 0xAC and second byte 0x53 is received, every other instruction is ignored. Loads and commits change nothing, reads and polls only echo, and `enabled_o` stays 0.
- R4: Every instruction is exactly four bytes long, and framing stays aligned across any sequence of instructions.
- R5: When enabled and not busy, opcodes 0x20 and 0x28 return, in the fourth byte slot, the low and high byte of the memory word. The word address is the lower 13 bits of {byte 2, byte 3}.
- R6: Opcode 0x40 loads the fourth byte into the low half of buffer word byte3[5:0]. Opcode 0x48 loads the high half, but only if that word's low half was loaded since the last commit. Otherwise the high load is ignored.
- R7: Opcode 0x4C commits the buffer to the page given by address bits [12:6]. Only words whose two halves were both loaded since the last commit change, and all other words keep their values. The commit then clears the buffer state.
- R8: A commit raises `busy_o` for exactly BUSY_CYCLES clocks. While busy, every instruction except poll is ignored, and reads only echo.
- R9: When enabled, opcode 0xF0 returns the busy state in bit 0 of the fourth byte slot, with bits 7..1 at zero.
- R10: Reset (active high) clears the bit and byte counters, the enabled and busy states and the buffer. It sets every memory word to 0xFFFF and drives `miso_o` to 0.
- R11: Pages at or above MEM_PAGES do not exist. A commit to such a page changes no word, and reads from such a page return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| enabled_o | output | 1 | Programming enable frame has been received |
| busy_o | output | 1 | Commit in progress |

## Verification
A slipped bit or byte counter shows up within one byte slot: the echoed bytes stop matching what the host sent a slot earlier. A wrong enable or busy state shows up at the fourth byte of the next read or poll, as an echo where data was due or the reverse. Stale or wrongly masked buffer state stays hidden until a commit is read back. For that reason, every commit is followed by reads of words that were loaded, words that were loaded only in part, and words that were left untouched.

// File: rtl/spi_isp_pkg.sv
package spi_isp_pkg;
  typedef logic [7:0] isp_byte_t;

  localparam isp_byte_t OP_ENABLE  = 8'hAC;
  localparam isp_byte_t EN_KEY     = 8'h53;
  localparam isp_byte_t OP_LOAD_LO = 8'h40;
  localparam isp_byte_t OP_LOAD_HI = 8'h48;
  localparam isp_byte_t OP_COMMIT  = 8'h4C;
  localparam isp_byte_t OP_READ_LO = 8'h20;
  localparam isp_byte_t OP_READ_HI = 8'h28;
  localparam isp_byte_t OP_POLL    = 8'hF0;
endpackage

// File: rtl/spi_isp_link.sv
module spi_isp_link
  import spi_isp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sck_i,
  input  logic      mosi_i,
  input  logic      tx_load_i,
  input  isp_byte_t tx_byte_i,
  output logic      rx_valid_o,
  output isp_byte_t rx_byte_o,
  output logic      sck_fall_o,
  output logic      miso_o
);
  logic [2:0] sck_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_q;
  logic [6:0] rx_sh;
  isp_byte_t  tx_sh;
  logic       sck_rise;

  assign sck_rise   = sck_q[1] & ~sck_q[2];
  assign sck_fall_o = ~sck_q[1] & sck_q[2];

  // two-stage synchronisers, third stage of sck for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q      <= '0;
      rx_sh      <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (sck_rise) begin
        bit_q <= bit_q + 3'd1;
        rx_sh <= {rx_sh[5:0], mosi_q[1]};
        if (bit_q == 3'd7) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {rx_sh, mosi_q[1]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      miso_o <= 1'b0;
    end else if (tx_load_i) begin
      tx_sh <= tx_byte_i;
    end else if (sck_fall_o) begin
      miso_o <= tx_sh[7];
      tx_sh  <= {tx_sh[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_isp_frame.sv
module spi_isp_frame
  import spi_isp_pkg::*;
#(
  parameter int ADDR_BITS = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid_i,
  input  isp_byte_t            rx_byte_i,
  input  logic                 busy_i,
  input  logic [15:0]          rd_data_i,
  output logic                 tx_load_o,
  output isp_byte_t            tx_byte_o,
  output logic [ADDR_BITS-1:0] rd_addr_o,
  output logic                 enabled_o,
  output logic                 ld_lo_o,
  output logic                 ld_hi_o,
  output logic                 commit_o,
  output logic [ADDR_BITS-1:0] cmd_addr_o,
  output isp_byte_t            cmd_data_o
);
  logic [1:0] idx_q;
  isp_byte_t  op_q, hi_q, lo_q;
  logic       en_q;
  logic       may_act;
  logic       exec;

  assign enabled_o = en_q;
  assign may_act   = en_q & ~busy_i;
  assign exec      = rx_valid_i & (idx_q == 2'd3);
  assign tx_load_o = rx_valid_i;
  assign rd_addr_o = ADDR_BITS'({hi_q, rx_byte_i});

  // response for the next slot: echo unless a read or poll answers
  always_comb begin
    tx_byte_o = rx_byte_i;
    if (idx_q == 2'd2 && en_q) begin
      if (op_q == OP_POLL)
        tx_byte_o = {7'd0, busy_i};
      else if (!busy_i && op_q == OP_READ_LO)
        tx_byte_o = rd_data_i[7:0];
      else if (!busy_i && op_q == OP_READ_HI)
        tx_byte_o = rd_data_i[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      op_q       <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      en_q       <= 1'b0;
      ld_lo_o    <= 1'b0;
      ld_hi_o    <= 1'b0;
      commit_o   <= 1'b0;
      cmd_addr_o <= '0;
      cmd_data_o <= '0;
    end else begin
      ld_lo_o  <= 1'b0;
      ld_hi_o  <= 1'b0;
      commit_o <= 1'b0;
      if (rx_valid_i) begin
        idx_q <= idx_q + 2'd1;
        case (idx_q)
          2'd0:    op_q <= rx_byte_i;
          2'd1:    hi_q <= rx_byte_i;
          2'd2:    lo_q <= rx_byte_i;
          default: ;
        endcase
      end
      if (exec) begin
        if (op_q == OP_ENABLE && hi_q == EN_KEY) en_q <= 1'b1;
        ld_lo_o    <= may_act && op_q == OP_LOAD_LO;
        ld_hi_o    <= may_act && op_q == OP_LOAD_HI;
        commit_o   <= may_act && op_q == OP_COMMIT;
        cmd_addr_o <= ADDR_BITS'({hi_q, lo_q});
        cmd_data_o <= rx_byte_i;
      end
    end
  end
endmodule

// File: rtl/spi_isp_store.sv
module spi_isp_store
  import spi_isp_pkg::*;
#(
  parameter int OFF_BITS    = 6,
  parameter int PAGE_BITS   = 7,
  parameter int MEM_PAGES   = 4,
  parameter int BUSY_CYCLES = 1500,
  localparam int ADDR_BITS  = OFF_BITS + PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_lo_i,
  input  logic                 ld_hi_i,
  input  logic                 commit_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  isp_byte_t            data_i,
  input  logic [ADDR_BITS-1:0] rd_addr_i,
  output logic [15:0]          rd_data_o,
  output logic                 busy_o
);
  localparam int PAGE_WORDS = 1 << OFF_BITS;
  localparam int PSEL_W     = $clog2(MEM_PAGES);
  localparam int MEM_WORDS  = MEM_PAGES * PAGE_WORDS;
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);
  localparam logic [PAGE_BITS-1:0] PAGE_LIM = PAGE_BITS'(MEM_PAGES);

  isp_byte_t             buf_lo [PAGE_WORDS];
  isp_byte_t             buf_hi [PAGE_WORDS];
  logic [PAGE_WORDS-1:0] lo_seen, word_ok;
  logic [15:0]           mem [MEM_WORDS];
  logic [CNT_W-1:0]      busy_cnt;

  logic [OFF_BITS-1:0]  wr_off, rd_off;
  logic [PAGE_BITS-1:0] wr_page, rd_page;
  logic                 wr_hit, rd_hit;

  assign wr_off  = addr_i[OFF_BITS-1:0];
  assign wr_page = addr_i[ADDR_BITS-1:OFF_BITS];
  assign wr_hit  = wr_page < PAGE_LIM;
  assign rd_off  = rd_addr_i[OFF_BITS-1:0];
  assign rd_page = rd_addr_i[ADDR_BITS-1:OFF_BITS];
  assign rd_hit  = rd_page < PAGE_LIM;

  assign rd_data_o = rd_hit ? mem[{rd_page[PSEL_W-1:0], rd_off}] : 16'hFFFF;
  assign busy_o    = |busy_cnt;

  // page buffer: low half first, high half accepted only after it
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_seen <= '0;
      word_ok <= '0;
      for (int i = 0; i < PAGE_WORDS; i++) begin
        buf_lo[i] <= '0;
        buf_hi[i] <= '0;
      end
    end else if (commit_i) begin
      lo_seen <= '0;
      word_ok <= '0;
    end else begin
      if (ld_lo_i) begin
        buf_lo[wr_off]  <= data_i;
        lo_seen[wr_off] <= 1'b1;
      end
      if (ld_hi_i && lo_seen[wr_off]) begin
        buf_hi[wr_off]  <= data_i;
        word_ok[wr_off] <= 1'b1;
      end
    end
  end

  // memory array: only fully loaded words of an existing page change
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (commit_i && wr_hit) begin
      for (int w = 0; w < PAGE_WORDS; w++)
        if (word_ok[w])
          mem[{wr_page[PSEL_W-1:0], OFF_BITS'(w)}] <= {buf_hi[w], buf_lo[w]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 busy_cnt <= '0;
    else if (commit_i)       busy_cnt <= CNT_W'(BUSY_CYCLES);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - CNT_W'(1);
  end
endmodule

// File: rtl/spi_isp_target.sv
module spi_isp_target
  import spi_isp_pkg::*;
#(
  parameter int OFF_BITS    = 6,
  parameter int PAGE_BITS   = 7,
  parameter int MEM_PAGES   = 4,
  parameter int BUSY_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic enabled_o,
  output logic busy_o
);
  localparam int ADDR_BITS = OFF_BITS + PAGE_BITS;

  logic                 rx_valid, tx_load, link_fall;
  isp_byte_t            rx_byte, tx_byte, cmd_data;
  logic                 ld_lo, ld_hi, commit;
  logic [ADDR_BITS-1:0] rd_addr, cmd_addr;
  logic [15:0]          rd_data;

  spi_isp_link u_link (
    .clk(clk), .rst(rst), .sck_i(sck_i), .mosi_i(mosi_i),
    .tx_load_i(tx_load), .tx_byte_i(tx_byte),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .sck_fall_o(link_fall), .miso_o(miso_o)
  );

  spi_isp_frame #(.ADDR_BITS(ADDR_BITS)) u_frame (
    .clk(clk), .rst(rst), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .busy_i(busy_o), .rd_data_i(rd_data),
    .tx_load_o(tx_load), .tx_byte_o(tx_byte), .rd_addr_o(rd_addr),
    .enabled_o(enabled_o), .ld_lo_o(ld_lo), .ld_hi_o(ld_hi),
    .commit_o(commit), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  spi_isp_store #(
    .OFF_BITS(OFF_BITS), .PAGE_BITS(PAGE_BITS),
    .MEM_PAGES(MEM_PAGES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_store (
    .clk(clk), .rst(rst), .ld_lo_i(ld_lo), .ld_hi_i(ld_hi),
    .commit_i(commit), .addr_i(cmd_addr), .data_i(cmd_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy_o)
  );
endmodule

// File: rtl/spi_isp_target_chk.sv
module spi_isp_target_chk #(
  parameter int BUSY_CYCLES = 1500
) (
  input logic clk,
  input logic rst,
  input logic sck_fall,
  input logic miso,
  input logic busy,
  input logic enabled,
  input logic ld_lo,
  input logic ld_hi,
  input logic commit
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  // R1: return line moves only after a serial clock falling edge
  a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
    $changed(miso) |-> $past(sck_fall));

  // R3: no buffer or commit action without the enable frame
  a_r3_act_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (ld_lo || ld_hi || commit) |-> enabled);

  // R3: enabled is only left through reset
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    !$fell(enabled));

  // R4: one decoded action per frame
  a_r4_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_lo, ld_hi, commit}));

  // R8: busy starts only from a commit
  a_r8_busy_from_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit));

  // R8: no commit accepted while busy
  a_r8_no_commit_busy: assert property (@(posedge clk) disable iff (rst)
    commit |-> !busy);

  // R8: busy lasts exactly BUSY_CYCLES
  a_r8_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_len == BUSY_CYCLES);
endmodule

bind spi_isp_target spi_isp_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .sck_fall(link_fall), .miso(miso_o),
  .busy(busy_o), .enabled(enabled_o), .ld_lo(ld_lo), .ld_hi(ld_hi),
  .commit(commit)
);

// File: tb/spi_isp_target_tb.sv
module spi_isp_target_tb;
  localparam int HP   = 8;
  localparam int BUSY = 1500;
  localparam int GAP  = 24;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, en, busy;

  always #4 clk = ~clk;

  spi_isp_target #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .enabled_o(en), .busy_o(busy)
  );

  int     checks = 0, errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference state
  logic [15:0] mm [256];
  logic [7:0]  mlo [64];
  logic [7:0]  mhi [64];
  bit          mseen [64];
  bit          mok [64];
  bit          men;
  logic [7:0]  mprev;
  longint      busy_until;

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) mm[i] = 16'hFFFF;
    for (int i = 0; i < 64; i++) begin
      mseen[i] = 0; mok[i] = 0; mlo[i] = 0; mhi[i] = 0;
    end
    men = 0; mprev = 8'h00; busy_until = 0;
  endfunction

  function automatic logic [7:0] mread(logic [7:0] h, logic [7:0] l, bit hi);
    int a = int'({h, l}) & 16'h1FFF;
    int pg = a >> 6;
    if (pg >= 4) return 8'hFF;
    return hi ? mm[pg*64 + (a & 63)][15:8] : mm[pg*64 + (a & 63)][7:0];
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit stable);
    stable = 1;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      if (miso !== rx[i]) stable = 0;
      sck = 1'b0;
    end
  endtask

  task automatic instr(string tag, logic [7:0] b0, logic [7:0] b1,
                       logic [7:0] b2, logic [7:0] b3);
    logic [7:0] b [4];
    logic [7:0] exp [4];
    logic [7:0] r;
    bit st;
    bit bz = cyc < busy_until;
    b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3;
    exp[0] = mprev; exp[1] = b0; exp[2] = b1; exp[3] = b2;
    if (men && b0 == 8'hF0)             exp[3] = {7'd0, bz};
    else if (men && !bz && b0 == 8'h20) exp[3] = mread(b1, b2, 0);
    else if (men && !bz && b0 == 8'h28) exp[3] = mread(b1, b2, 1);
    for (int k = 0; k < 4; k++) begin
      xfer(b[k], r, st);
      check("R1 stable while sck high", 32'(st), 32'd1);
      if (k == 0)      check("R4 frame start echo", 32'(r), 32'(exp[0]));
      else if (k < 3)  check("R2 echo", 32'(r), 32'(exp[k]));
      else             check(tag, 32'(r), 32'(exp[3]));
    end
    if (b0 == 8'hAC && b1 == 8'h53) men = 1;
    else if (men && !bz) begin
      int off = int'(b2[5:0]);
      int a = int'({b1, b2}) & 16'h1FFF;
      if (b0 == 8'h40) begin mlo[off] = b3; mseen[off] = 1; end
      if (b0 == 8'h48 && mseen[off]) begin mhi[off] = b3; mok[off] = 1; end
      if (b0 == 8'h4C) begin
        if ((a >> 6) < 4)
          for (int w = 0; w < 64; w++)
            if (mok[w]) mm[(a >> 6)*64 + w] = {mhi[w], mlo[w]};
        for (int w = 0; w < 64; w++) begin mseen[w] = 0; mok[w] = 0; end
        busy_until = cyc + BUSY;
      end
    end
    mprev = b3;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (BUSY + 200) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] junk;
    bit st;
    model_reset();
    do_reset();
    check("R10 miso after reset", 32'(miso), 32'd0);
    check("R10 enabled after reset", 32'(en), 32'd0);
    check("R10 busy after reset", 32'(busy), 32'd0);

    // R3: everything ignored before enable
    instr("R3 load ignored", 8'h40, 8'h00, 8'h03, 8'hAA);
    instr("R3 load ignored", 8'h48, 8'h00, 8'h03, 8'hBB);
    instr("R3 commit ignored", 8'h4C, 8'h00, 8'h00, 8'h00);
    check("R3 no busy before enable", 32'(busy), 32'd0);
    instr("R3 read echoes", 8'h20, 8'h00, 8'h03, 8'h00);
    instr("R3 poll echoes", 8'hF0, 8'h00, 8'h5A, 8'h00);
    check("R3 still disabled", 32'(en), 32'd0);

    // R2: enable frame, 0x53 echoed in third slot
    instr("R2 enable", 8'hAC, 8'h53, 8'h00, 8'h00);
    check("R3 enabled", 32'(en), 32'd1);
    instr("R5 erased read", 8'h20, 8'h00, 8'h03, 8'h00);

    // R6, R7: page 1 loads
    instr("R6 lo w3", 8'h40, 8'h00, 8'h03, 8'h34);
    instr("R6 hi w3", 8'h48, 8'h00, 8'h03, 8'h12);
    instr("R6 lo only w10", 8'h40, 8'h00, 8'h0A, 8'h78);
    instr("R6 hi without lo w20", 8'h48, 8'h00, 8'h14, 8'h9C);
    instr("R7 commit page1", 8'h4C, 8'h00, 8'h40, 8'h00);
    check("R8 busy after commit", 32'(busy), 32'd1);
    instr("R9 poll busy", 8'hF0, 8'h00, 8'h00, 8'h00);
    instr("R8 load ignored busy", 8'h40, 8'h00, 8'h05, 8'h99);
    wait_idle();
    check("R8 busy cleared", 32'(busy), 32'd0);
    instr("R9 poll idle", 8'hF0, 8'h00, 8'h00, 8'h00);
    instr("R5 read lo w3", 8'h20, 8'h00, 8'h43, 8'h00);
    instr("R5 read hi w3", 8'h28, 8'h00, 8'h43, 8'h00);
    instr("R6 partial word unchanged", 8'h20, 8'h00, 8'h4A, 8'h00);
    instr("R6 hi-only word unchanged", 8'h28, 8'h00, 8'h54, 8'h00);
    instr("R7 other page unchanged", 8'h20, 8'h00, 8'h03, 8'h00);
    instr("R5 upper address bits ignored", 8'h28, 8'hE0, 8'h43, 8'h00);

    // R6: busy-time low load must not enable a high load; R7 keeps w3
    instr("R6 hi after ignored lo", 8'h48, 8'h00, 8'h05, 8'h77);
    instr("R6 lo w5", 8'h40, 8'h00, 8'h05, 8'h66);
    instr("R6 hi w5", 8'h48, 8'h00, 8'h05, 8'h55);
    instr("R7 commit page1 again", 8'h4C, 8'h00, 8'h40, 8'h00);
    instr("R8 read echoes busy", 8'h20, 8'h00, 8'h43, 8'h00);
    wait_idle();
    instr("R7 w5 written", 8'h28, 8'h00, 8'h45, 8'h00);
    instr("R7 w3 kept", 8'h20, 8'h00, 8'h43, 8'h00);
    instr("R7 w3 kept hi", 8'h28, 8'h00, 8'h43, 8'h00);

    // R11: last page exists, page 5 does not
    instr("R6 lo p3", 8'h40, 8'h00, 8'h07, 8'hC3);
    instr("R6 hi p3", 8'h48, 8'h00, 8'h07, 8'h3C);
    instr("R11 commit page3", 8'h4C, 8'h00, 8'hC0, 8'h00);
    wait_idle();
    instr("R11 page3 read", 8'h28, 8'h00, 8'hC7, 8'h00);
    instr("R6 lo p5", 8'h40, 8'h00, 8'h00, 8'h11);
    instr("R6 hi p5", 8'h48, 8'h00, 8'h00, 8'h22);
    instr("R11 commit page5", 8'h4C, 8'h01, 8'h40, 8'h00);
    wait_idle();
    instr("R11 absent page reads FF", 8'h20, 8'h01, 8'h40, 8'h00);
    instr("R11 page0 untouched", 8'h20, 8'h00, 8'h00, 8'h00);

    // R10: reset in the middle of a frame
    xfer(8'h20, junk, st);
    xfer(8'h00, junk, st);
    do_reset();
    check("R10 enabled cleared", 32'(en), 32'd0);
    check("R10 miso cleared", 32'(miso), 32'd0);
    instr("R10 read after reset echoes", 8'h20, 8'h00, 8'h43, 8'h00);
    instr("R2 re-enable", 8'hAC, 8'h53, 8'h00, 8'h00);
    instr("R10 memory erased", 8'h28, 8'h00, 8'h43, 8'h00);
    instr("R4 alignment kept", 8'h20, 8'h00, 8'h45, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule